// File: doc/BRIEF.md
# Triggered Hit-Pattern Capture Pipeline

The block samples a 64-bit word of discriminator hits on every edge of the beam-synchronous clock and keeps the most recent 1024 samples in a circular delay line. A second-level trigger decision arrives a fixed number of clocks after the beam crossing that caused it. The block therefore reads the sample at a programmable delay behind the current write position. That sample is the hit pattern of the crossing the trigger refers to.

Each accepted trigger produces one event. The event is written to an external 4096 x 32 event memory as two words on two consecutive clocks. The low half goes to an even address and the high half to the following odd address. The block counts stored events. It holds one trigger that arrives while a write is in progress. It raises busy and a one-cycle interrupt once the memory can no longer take a complete event. It releases busy when the reader acknowledges consumed events or when a fast clear resets the write side.

Top module: `trig_hit_capture`

## Requirements
- R1: The word stored for a trigger sampled at clock edge T with delay setting D is the `hit_i` value sampled at edge T-D. D ranges from 1 to 1023, and D = 0 selects a delay of 1024.
- R2: Write timing. The cycle after the trigger edge shows `mem_we_o` = 1 with `hit[31:0]` at an even address. The next cycle shows `hit[63:32]` at that address plus one. `mem_we_o` is 0 otherwise.
- R3: Successive events take successive address pairs. The address wraps from 4095 to 0.
- R4: A trigger sampled on the edge that writes a high word is held. Its event is written in the two cycles directly after, using the sample selected at its own arrival edge.
- R5: A trigger is ignored while fewer clock edges than the selected delay have passed since reset.
- R6: `evt_cnt_o` increases by exactly one for each stored event.
- R7: Occupancy counts written words not yet acknowledged. `busy_o` is 1 while occupancy is 4094 or more. Triggers are ignored while `busy_o` is 1. `irq_o` pulses for one cycle when `busy_o` rises.
- R8: A pulse on `ack_i` frees one event, which is two words. When this takes occupancy below 4094, `busy_o` falls on the next cycle.
- R9: `fclr_i` clears the write address, occupancy, event counter and any held trigger. The next event is then written at address 0 and `busy_o` is 0.
- R10: After reset, `mem_we_o`, `busy_o`, `irq_o` and `evt_cnt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Beam-synchronous sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 64 | Discriminator hit pattern |
| trig_i | input | 1 | Second-level trigger accept |
| dly_i | input | 10 | Delay tap setting in clocks (0 selects 1024) |
| fclr_i | input | 1 | Fast clear of the write side |
| ack_i | input | 1 | Reader has consumed one event |
| mem_we_o | output | 1 | Event memory write strobe |
| mem_addr_o | output | 12 | Event memory write address |
| mem_data_o | output | 32 | Event memory write data |
| busy_o | output | 1 | Memory full, triggers vetoed |
| irq_o | output | 1 | One-cycle pulse when busy rises |
| evt_cnt_o | output | 16 | Stored event count |

## Verification
The full boundary is the hardest state to reach. It needs 2047 stored events with no acknowledge. The bench drives that many triggers back to back from a cleared state. It checks that busy is still low after event 2046 and rises with irq after event 2047. It then checks that a vetoed trigger leaves the outputs untouched, and uses single acknowledges to show busy releasing, the write address landing on 4094 and then wrapping to 0. The held trigger is reached by keeping the trigger high for two consecutive edges, so that the second edge falls on the high-word write.

// File: rtl/hc_pkg.sv
package hc_pkg;
  typedef enum logic {
    HC_IDLE = 1'b0,
    HC_HI   = 1'b1
  } hc_wr_e;
endpackage

// File: rtl/hc_pipe.sv
module hc_pipe #(
  parameter int W     = 64,
  parameter int DEPTH = 1024
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [W-1:0]               hit_i,
  input  logic [$clog2(DEPTH)-1:0]   dly_i,
  output logic [W-1:0]               word_o,
  output logic                       ready_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_FILL = (AW+1)'(DEPTH);

  logic [W-1:0]  ring [DEPTH];
  logic [AW-1:0] wp_q;
  logic [AW:0]   fill_q;
  logic [AW:0]   need;

  always_ff @(posedge clk_i) ring[wp_q] <= hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      fill_q <= '0;
    end else begin
      wp_q <= wp_q + 1'b1;
      if (fill_q != FULL_FILL) fill_q <= fill_q + 1'b1;
    end
  end

  // zero delay wraps to the full ring depth
  assign need    = (dly_i == '0) ? FULL_FILL : {1'b0, dly_i};
  assign ready_o = (fill_q >= need);
  assign word_o  = ring[wp_q - dly_i];

  // R5
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && $stable(dly_i) |=> ready_o);
endmodule

// File: rtl/hc_serial.sv
module hc_serial
  import hc_pkg::*;
#(
  parameter int W  = 64,
  parameter int AW = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            trig_i,
  input  logic            ready_i,
  input  logic            veto_i,
  input  logic [W-1:0]    word_i,
  input  logic [AW-1:0]   base_i,
  output logic            we_o,
  output logic [AW-1:0]   addr_o,
  output logic [W/2-1:0]  data_o,
  output logic            done_o
);
  localparam int HW = W / 2;

  hc_wr_e        st_q;
  logic          pend_q;
  logic [W-1:0]  pend_w_q;
  logic [HW-1:0] hi_q;
  logic          take, go;
  logic [W-1:0]  go_w;

  assign take   = trig_i && ready_i && !veto_i;
  assign go     = !veto_i && (pend_q || (trig_i && ready_i));
  assign go_w   = pend_q ? pend_w_q : word_i;
  assign done_o = (st_q == HC_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= HC_IDLE;
      pend_q   <= 1'b0;
      pend_w_q <= '0;
      hi_q     <= '0;
      we_o     <= 1'b0;
      addr_o   <= '0;
      data_o   <= '0;
    end else if (clr_i) begin
      st_q   <= HC_IDLE;
      pend_q <= 1'b0;
      we_o   <= 1'b0;
    end else begin
      unique case (st_q)
        HC_IDLE: begin
          pend_w_q <= word_i;
          pend_q   <= go && pend_q && take;
          if (go) begin
            we_o   <= 1'b1;
            addr_o <= base_i;
            data_o <= go_w[HW-1:0];
            hi_q   <= go_w[W-1:HW];
            st_q   <= HC_HI;
          end else begin
            we_o <= 1'b0;
          end
        end
        HC_HI: begin
          we_o   <= 1'b1;
          addr_o <= {base_i[AW-1:1], 1'b1};
          data_o <= hi_q;
          st_q   <= HC_IDLE;
          if (take) begin
            pend_q   <= 1'b1;
            pend_w_q <= word_i;
          end
        end
        default: st_q <= HC_IDLE;
      endcase
    end
  end

  // R2
  pair_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o && !addr_o[0] && !clr_i |=> we_o && addr_o[0]);

  // R7
  no_write_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == HC_IDLE) && veto_i |=> !we_o);
endmodule

// File: rtl/hc_ptr.sv
module hc_ptr #(
  parameter int AW = 12,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          done_i,
  input  logic          ack_i,
  output logic [AW-1:0] base_o,
  output logic          full_o,
  output logic          irq_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [AW:0] CAP     = (AW+1)'(1 << AW);
  localparam logic [AW:0] FULL_AT = CAP - (AW+1)'(2);
  localparam logic [AW:0] TWO     = (AW+1)'(2);

  logic [AW-1:0] wp_q;
  logic [AW:0]   occ_q;
  logic          full_d_q;
  logic [CW-1:0] cnt_q;
  logic          freed;

  assign freed  = ack_i && (occ_q >= TWO);
  assign full_o = (occ_q >= FULL_AT);
  assign irq_o  = full_o && !full_d_q;
  assign base_o = wp_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q     <= '0;
      occ_q    <= '0;
      full_d_q <= 1'b0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wp_q     <= '0;
      occ_q    <= '0;
      full_d_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      full_d_q <= full_o;
      if (done_i) begin
        wp_q  <= wp_q + AW'(2);
        cnt_q <= cnt_q + 1'b1;
      end
      case ({done_i, freed})
        2'b10:   occ_q <= occ_q + TWO;
        2'b01:   occ_q <= occ_q - TWO;
        default: occ_q <= occ_q;
      endcase
    end
  end

  // R7
  occ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= CAP);

  // R6
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q - $past(cnt_q)) <= CW'(1));

  // R8
  ack_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !done_i && !clr_i && (occ_q >= TWO) |=> occ_q == $past(occ_q) - TWO);
endmodule

// File: rtl/trig_hit_capture.sv
module trig_hit_capture #(
  parameter int HIT_W      = 64,
  parameter int PIPE_DEPTH = 1024,
  parameter int MEM_DEPTH  = 4096,
  parameter int CNT_W      = 16,
  localparam int DW        = $clog2(PIPE_DEPTH),
  localparam int AW        = $clog2(MEM_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HIT_W-1:0]   hit_i,
  input  logic               trig_i,
  input  logic [DW-1:0]      dly_i,
  input  logic               fclr_i,
  input  logic               ack_i,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [HIT_W/2-1:0] mem_data_o,
  output logic               busy_o,
  output logic               irq_o,
  output logic [CNT_W-1:0]   evt_cnt_o
);
  logic [HIT_W-1:0] tap_word;
  logic             tap_ready;
  logic [AW-1:0]    base;
  logic             full;
  logic             done;

  hc_pipe #(.W(HIT_W), .DEPTH(PIPE_DEPTH)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit_i),
    .dly_i   (dly_i),
    .word_o  (tap_word),
    .ready_o (tap_ready)
  );

  hc_serial #(.W(HIT_W), .AW(AW)) u_serial (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fclr_i),
    .trig_i  (trig_i),
    .ready_i (tap_ready),
    .veto_i  (full),
    .word_i  (tap_word),
    .base_i  (base),
    .we_o    (mem_we_o),
    .addr_o  (mem_addr_o),
    .data_o  (mem_data_o),
    .done_o  (done)
  );

  hc_ptr #(.AW(AW), .CW(CNT_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (fclr_i),
    .done_i (done),
    .ack_i  (ack_i),
    .base_o (base),
    .full_o (full),
    .irq_o  (irq_o),
    .cnt_o  (evt_cnt_o)
  );

  assign busy_o = full;
endmodule

// File: tb/sim_trig_hit_capture.sv
module sim_trig_hit_capture;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] hit_i = '0;
  logic        trig_i = 1'b0;
  logic [9:0]  dly_i = 10'd20;
  logic        fclr_i = 1'b0;
  logic        ack_i = 1'b0;
  logic        mem_we_o;
  logic [11:0] mem_addr_o;
  logic [31:0] mem_data_o;
  logic        busy_o;
  logic        irq_o;
  logic [15:0] evt_cnt_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_addr = 0;
  int exp_cnt = 0;

  trig_hit_capture u0 (.*);

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

  function automatic logic [63:0] pat(input int k);
    return {32'(k) * 32'h0100_0193 + 32'h0000_00C3, 32'(k) ^ 32'hA5A5_0000};
  endfunction

  always @(negedge clk_i) hit_i <= pat(cyc);

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one event with delay d; optional checking of both words
  task automatic do_event(input int d, input bit chk, input string tag);
    int t;
    logic [63:0] w;
    @(negedge clk_i);
    t = cyc;
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
    w = pat(t - d);
    if (chk) check(mem_we_o && mem_addr_o == 12'(exp_addr) && mem_data_o == w[31:0],
                   {tag, " low word"}, {mem_we_o, mem_addr_o, mem_data_o},
                   {1'b1, 12'(exp_addr), w[31:0]});
    @(negedge clk_i);
    if (chk) check(mem_we_o && mem_addr_o == 12'(exp_addr + 1) && mem_data_o == w[63:32],
                   {tag, " high word"}, {mem_we_o, mem_addr_o, mem_data_o},
                   {1'b1, 12'(exp_addr + 1), w[63:32]});
    exp_addr = (exp_addr + 2) % 4096;
    exp_cnt++;
    @(negedge clk_i);
    if (chk) check(!mem_we_o && evt_cnt_o == 16'(exp_cnt), {tag, " idle/count R6"},
                   {mem_we_o, evt_cnt_o}, {1'b0, 16'(exp_cnt)});
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    check(!mem_we_o && !busy_o && !irq_o && evt_cnt_o == 0, "R10 reset state",
          {mem_we_o, busy_o, irq_o, evt_cnt_o}, '0);
  endtask

  task automatic t_early;
    bit seen = 0;
    while (cyc < 5) @(negedge clk_i);
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (mem_we_o) seen = 1;
      @(negedge clk_i);
    end
    check(!seen && evt_cnt_o == 0, "R5 early trigger ignored", {seen, evt_cnt_o}, '0);
  endtask

  task automatic t_basic;
    while (cyc < 60) @(negedge clk_i);
    dly_i = 10'd5;
    do_event(5, 1, "R1 R2 d5");
    dly_i = 10'd37;
    do_event(37, 1, "R1 R2 R3 d37");
  endtask

  task automatic t_pending;
    int t;
    logic [63:0] a, b;
    dly_i = 10'd9;
    @(negedge clk_i);
    t = cyc;
    trig_i = 1'b1;
    a = pat(t - 9);
    b = pat(t + 1 - 9);
    @(negedge clk_i);
    check(mem_we_o && mem_addr_o == 12'(exp_addr) && mem_data_o == a[31:0],
          "R4 first low", {mem_addr_o, mem_data_o}, {12'(exp_addr), a[31:0]});
    @(negedge clk_i);
    trig_i = 1'b0;
    check(mem_we_o && mem_addr_o == 12'(exp_addr + 1) && mem_data_o == a[63:32],
          "R4 first high", {mem_addr_o, mem_data_o}, {12'(exp_addr + 1), a[63:32]});
    @(negedge clk_i);
    check(mem_we_o && mem_addr_o == 12'(exp_addr + 2) && mem_data_o == b[31:0],
          "R4 held low", {mem_addr_o, mem_data_o}, {12'(exp_addr + 2), b[31:0]});
    @(negedge clk_i);
    check(mem_we_o && mem_addr_o == 12'(exp_addr + 3) && mem_data_o == b[63:32],
          "R4 held high", {mem_addr_o, mem_data_o}, {12'(exp_addr + 3), b[63:32]});
    exp_addr = exp_addr + 4;
    exp_cnt = exp_cnt + 2;
    @(negedge clk_i);
    check(!mem_we_o && evt_cnt_o == 16'(exp_cnt), "R4 R6 after held",
          {mem_we_o, evt_cnt_o}, {1'b0, 16'(exp_cnt)});
  endtask

  task automatic t_deep;
    while (cyc < 1100) @(negedge clk_i);
    dly_i = 10'd1023;
    do_event(1023, 1, "R1 d1023");
    dly_i = 10'd0;
    do_event(1024, 1, "R1 d0=1024");
    dly_i = 10'd3;
  endtask

  task automatic t_fclr;
    @(negedge clk_i);
    fclr_i = 1'b1;
    @(negedge clk_i);
    fclr_i = 1'b0;
    exp_addr = 0;
    exp_cnt = 0;
    check(evt_cnt_o == 0 && !busy_o && !mem_we_o, "R9 clear state",
          {evt_cnt_o, busy_o, mem_we_o}, '0);
    do_event(3, 1, "R9 after clear");
  endtask

  task automatic t_full;
    bit seen = 0;
    @(negedge clk_i);
    fclr_i = 1'b1;
    @(negedge clk_i);
    fclr_i = 1'b0;
    exp_addr = 0;
    exp_cnt = 0;
    for (int i = 0; i < 2046; i++) do_event(3, 0, "fill");
    check(!busy_o && evt_cnt_o == 16'd2046, "R7 not full at 4092",
          {busy_o, evt_cnt_o}, {1'b0, 16'd2046});
    do_event(3, 1, "R7 last fit");
    check(busy_o, "R7 busy at 4094", busy_o, 1);
    // irq was visible one cycle earlier; it must now be gone
    check(!irq_o, "R7 irq one cycle", irq_o, 0);
    @(negedge clk_i);
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (mem_we_o) seen = 1;
      @(negedge clk_i);
    end
    check(!seen && evt_cnt_o == 16'(exp_cnt) && busy_o, "R7 vetoed trigger",
          {seen, evt_cnt_o, busy_o}, {1'b0, 16'(exp_cnt), 1'b1});
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    check(!busy_o, "R8 ack releases busy", busy_o, 0);
    do_event(3, 1, "R3 R8 addr 4094");
    check(busy_o, "R7 busy again", busy_o, 1);
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    do_event(3, 1, "R3 wrap to 0");
  endtask

  task automatic t_irq_edge;
    // rebuild full from clear and look at irq on the completing cycle
    @(negedge clk_i);
    fclr_i = 1'b1;
    @(negedge clk_i);
    fclr_i = 1'b0;
    exp_addr = 0;
    exp_cnt = 0;
    for (int i = 0; i < 2046; i++) do_event(3, 0, "fill");
    @(negedge clk_i);
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
    @(negedge clk_i);
    check(irq_o && busy_o, "R7 irq pulse", {irq_o, busy_o}, 2'b11);
    exp_addr = (exp_addr + 2) % 4096;
    exp_cnt++;
    @(negedge clk_i);
    check(!irq_o && busy_o, "R7 irq drop", {irq_o, busy_o}, 2'b01);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_early();
    t_basic();
    t_pending();
    t_deep();
    t_fclr();
    t_full();
    t_irq_edge();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule